// File: doc/BRIEF.md
# CPU Bus Wait-State Inserter

This block sits beside an 8-bit CPU with a multiplexed strobe bus. It watches the fetch, memory-request, I/O-request, read and write strobes. It drives the CPU's active-low wait input so that memory machine cycles are stretched by whole T-states. The CPU clock is never gated. The clock runs freely, and the block issues a synchronous wait request that is registered on the edge that closes the first T-state. The CPU samples that request at the end of T2 and repeats T2 for as long as the request stays low.

A two-bit mode input selects the stretching policy:

- no stretching;
- a fixed number of waits on opcode fetches only;
- the same fixed number of waits on every memory access;
- slot alignment, which pads each access so that it completes on a boundary of a free-running four-T-state grid.

Independently of the mode, a memory controller can hold its active-high ready input low to buy more T-states. A controller can use that time, for example, to redirect a write to a different physical memory before the write strobe is committed. I/O cycles and refresh cycles pass untouched.

Top module: `wsi_wait_inserter`

## Requirements
- R1: While reset is low, and afterwards until an access is recognized, wait_n is high. The slot phase counter restarts from zero, and the first clock edge after reset release counts as phase 0.
- R2: A memory access is recognized on the first clock edge at which mreq_n is low, iorq_n is high, and rd_n or wr_n is low. When the policy calls for waits, wait_n goes low directly after that edge. The number of waits W is the number of consecutive following edges at which wait_n is low.
- R3: In mode 0, an access with mem_ready high gets W = 0.
- R4: In mode 1, an access with m1_n low at the recognition edge gets W = EXTRA_WAITS (default 1), and any other memory access gets W = 0.
- R5: In mode 2, every memory read, write or fetch gets W = EXTRA_WAITS.
- R6: In mode 3, W = SLOT_LEN-1-p, where p is the count of edges since reset release, modulo SLOT_LEN, at the recognition edge. As a result, wait_n rises on the edge at which the phase wraps to zero.
- R7: If mem_ready is low on the recognition edge and on the following edges, R edges in a row, then W = max(mode waits, R). Otherwise mem_ready has no effect.
- R8: An I/O cycle (iorq_n low), or a refresh-like request (mreq_n low with rd_n and wr_n both high), gets W = 0 whatever the mode and mem_ready.
- R9: An access held for several T-states is recognized once. After wait_n has risen, it stays high until the strobes have been released for at least one edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running CPU clock, one T-state per period |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | 0 none, 1 fetch only, 2 every memory access, 3 slot alignment |
| m1_n | input | 1 | Opcode-fetch strobe, active low |
| mreq_n | input | 1 | Memory-request strobe, active low |
| iorq_n | input | 1 | I/O-request strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| mem_ready | input | 1 | Memory controller ready, active high |
| wait_n | output | 1 | Registered wait request to the CPU, active low |

## Verification
The bench builds the block with the default SLOT_LEN of 4 and EXTRA_WAITS of 1. At that size, every slot phase is reached simply by varying the idle gap between accesses. The bench sweeps all four modes against all five bus cycle kinds (fetch, read, write, I/O, refresh), three ready-delay lengths and four idle gaps. This covers every combination of slot phase, policy and controller stretch. Its bus model counts the repeated T2 states directly and compares them with max(policy waits, ready delay), which it computes from its own edge count.

// File: rtl/wsi_pkg.sv
package wsi_pkg;

  typedef enum logic [1:0] {
    WM_NONE  = 2'd0,
    WM_FETCH = 2'd1,
    WM_ANY   = 2'd2,
    WM_SLOT  = 2'd3
  } wait_mode_e;

  // Number of policy waits chosen at the recognition edge.
  function automatic int unsigned policy_waits(wait_mode_e m, logic is_fetch,
                                               int unsigned phase,
                                               int unsigned slot_len,
                                               int unsigned extra);
    int unsigned w;
    case (m)
      WM_NONE:  w = 0;
      WM_FETCH: w = is_fetch ? extra : 0;
      WM_ANY:   w = extra;
      default:  w = slot_len - 1 - phase;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/wsi_slot_phase.sv
module wsi_slot_phase #(
  parameter int SLOT_LEN = 4,
  parameter int PH_W     = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [PH_W-1:0] phase
);
  logic [PH_W-1:0] phase_q;

  generate
    if ((1 << PH_W) == SLOT_LEN) begin : g_pow2
      always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= '0;
        else        phase_q <= phase_q + PH_W'(1);
      end
    end else begin : g_wrap
      always_ff @(posedge clk) begin
        if (!rst_n)                             phase_q <= '0;
        else if (phase_q == PH_W'(SLOT_LEN-1))  phase_q <= '0;
        else                                    phase_q <= phase_q + PH_W'(1);
      end
    end
  endgenerate

  assign phase = phase_q;
endmodule

// File: rtl/wsi_access_detect.sv
module wsi_access_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic m1_n,
  input  logic mreq_n,
  input  logic iorq_n,
  input  logic rd_n,
  input  logic wr_n,
  output logic access_start,
  output logic fetch_start
);
  logic access_now;
  logic access_q;

  assign access_now = !mreq_n && iorq_n && (!rd_n || !wr_n);

  always_ff @(posedge clk) begin
    if (!rst_n) access_q <= 1'b0;
    else        access_q <= access_now;
  end

  assign access_start = access_now && !access_q;
  assign fetch_start  = access_start && !m1_n;
endmodule

// File: rtl/wsi_wait_seq.sv
module wsi_wait_seq #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] base,
  input  logic             mem_ready,
  output logic             hold
);
  logic             hold_q;
  logic [CNT_W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      left_q <= '0;
    end else if (start) begin
      hold_q <= (base != '0) || !mem_ready;
      left_q <= (base != '0) ? base - CNT_W'(1) : '0;
    end else if (hold_q) begin
      if (left_q != '0)   left_q <= left_q - CNT_W'(1);
      else if (mem_ready) hold_q <= 1'b0;
    end
  end

  assign hold = hold_q;
endmodule

// File: rtl/wsi_wait_inserter.sv
module wsi_wait_inserter #(
  parameter int SLOT_LEN    = 4,
  parameter int EXTRA_WAITS = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       m1_n,
  input  logic       mreq_n,
  input  logic       iorq_n,
  input  logic       rd_n,
  input  logic       wr_n,
  input  logic       mem_ready,
  output logic       wait_n
);
  import wsi_pkg::*;

  localparam int PH_W  = (SLOT_LEN > 1) ? $clog2(SLOT_LEN) : 1;
  localparam int MAX_W = (SLOT_LEN - 1 > EXTRA_WAITS) ? SLOT_LEN - 1 : EXTRA_WAITS;
  localparam int CNT_W = (MAX_W > 0) ? $clog2(MAX_W + 1) : 1;

  logic [PH_W-1:0]  slot_phase;
  logic             access_start;
  logic             fetch_start;
  logic [CNT_W-1:0] base_waits;
  logic             hold;

  wsi_slot_phase #(.SLOT_LEN(SLOT_LEN), .PH_W(PH_W)) phase_i (
    .clk   (clk),
    .rst_n (rst_n),
    .phase (slot_phase)
  );

  wsi_access_detect detect_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .m1_n         (m1_n),
    .mreq_n       (mreq_n),
    .iorq_n       (iorq_n),
    .rd_n         (rd_n),
    .wr_n         (wr_n),
    .access_start (access_start),
    .fetch_start  (fetch_start)
  );

  assign base_waits = CNT_W'(policy_waits(wait_mode_e'(mode), fetch_start,
                                          int'(slot_phase), SLOT_LEN, EXTRA_WAITS));

  wsi_wait_seq #(.CNT_W(CNT_W)) seq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (access_start),
    .base      (base_waits),
    .mem_ready (mem_ready),
    .hold      (hold)
  );

  assign wait_n = !hold;
endmodule

// File: rtl/wsi_wait_inserter_chk.sv
module wsi_wait_inserter_chk #(
  parameter int EXTRA_WAITS = 1
) (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode,
  input logic       iorq_n,
  input logic       mem_ready,
  input logic       wait_n,
  input logic       access_start,
  input logic       fetch_start
);
  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> wait_n);

  assert_none_mode_free_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && mem_ready && wait_n) |=> wait_n);

  assert_fetch_waits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (EXTRA_WAITS > 0 && fetch_start && mode == 2'd1) |=> !wait_n);

  assert_any_waits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (EXTRA_WAITS > 0 && access_start && mode == 2'd2) |=> !wait_n);

  assert_ready_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wait_n && !mem_ready) |=> !wait_n);

  assert_io_passes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!iorq_n && wait_n) |=> wait_n);
endmodule

bind wsi_wait_inserter wsi_wait_inserter_chk #(.EXTRA_WAITS(EXTRA_WAITS)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .mode         (mode),
  .iorq_n       (iorq_n),
  .mem_ready    (mem_ready),
  .wait_n       (wait_n),
  .access_start (access_start),
  .fetch_start  (fetch_start)
);

// File: tb/wsi_wait_inserter_tb.sv
`timescale 1ns/1ps
module wsi_wait_inserter_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'd3;
  logic       m1_n = 1'b1, mreq_n = 1'b1, iorq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic       mem_ready = 1'b1;
  logic       wait_n;

  int total = 0;
  int bad   = 0;
  int edge_cnt = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  wsi_wait_inserter dut_i (
    .clk(clk), .rst_n(rst_n), .mode(mode), .m1_n(m1_n), .mreq_n(mreq_n),
    .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n), .mem_ready(mem_ready),
    .wait_n(wait_n)
  );

  always @(posedge clk) begin
    if (rst_n) edge_cnt <= edge_cnt + 1;
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      total++; bad++;
      $display("FAIL R9 watchdog expired actual=%0d expected=%0d", cyc, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // kind: 0 fetch, 1 read, 2 write, 3 io, 4 refresh
  task automatic bus_cycle(input int kind, input int r, input int pad);
    int p, base, exp, w, first;
    string tag;
    repeat (pad) @(negedge clk);
    p = edge_cnt % 4;
    case (kind)
      0: begin m1_n = 0; mreq_n = 0; rd_n = 0; end
      1: begin mreq_n = 0; rd_n = 0; end
      2: begin mreq_n = 0; wr_n = 0; end   // R2: write recognized by wr_n
      3: begin iorq_n = 0; rd_n = 0; end
      default: begin mreq_n = 0; end
    endcase
    mem_ready = (r == 0);
    case (mode)
      2'd0: begin base = 0; tag = "R3"; end
      2'd1: begin base = (kind == 0) ? 1 : 0; tag = "R4"; end
      2'd2: begin base = 1; tag = "R5"; end
      default: begin base = (4 - ((p + 1) % 4)) % 4; tag = "R6"; end
    endcase
    if (kind >= 3) begin exp = 0; tag = "R8"; end
    else begin
      exp = (r > base) ? r : base;
      if (r > base) tag = "R7";
    end
    w = 0; first = 1;
    for (int j = 0; j < 20; j++) begin
      @(negedge clk);
      mem_ready = (j + 1 >= r);
      if (j == 0) first = int'(wait_n);
      if (wait_n) break;
      w++;
    end
    check(w == exp, tag, w, exp);
    check(first == ((exp > 0) ? 0 : 1), "R2", first, (exp > 0) ? 0 : 1);
    @(negedge clk);   // strobes still held: no retrigger
    check(wait_n == 1'b1, "R9", int'(wait_n), 1);
    m1_n = 1; mreq_n = 1; iorq_n = 1; rd_n = 1; wr_n = 1; mem_ready = 1;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(wait_n == 1'b1, "R1", int'(wait_n), 1);
    rst_n = 1'b1;
    // first edge after release is phase 0 -> three slot waits (R1, R6)
    bus_cycle(0, 0, 0);
    for (int m = 0; m < 4; m++) begin
      mode = 2'(m);
      for (int k = 0; k < 5; k++)
        for (int ri = 0; ri < 3; ri++)
          for (int pad = 0; pad < 4; pad++)
            bus_cycle(k, (ri == 2) ? 3 : ri, pad);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule